// File: doc/BRIEF.md
# Sequential Double-Width Integer Divider

This block divides a dividend of twice the data width, presented as an upper and a lower half, by a single-width divisor. It returns a single-width quotient and remainder. Unsigned or two's-complement signed interpretation is chosen for each operation. The block produces one quotient bit per clock with a restoring shift-and-subtract loop. Operands are captured on a start pulse. The block is busy while it iterates and raises a one-cycle done pulse that carries a status code.

A zero divisor, or a quotient too wide for the data width, ends the operation with an error code. In that case no result is written. Signed operands are turned into magnitudes before the loop. The signs are restored in a final fix-up cycle, and that cycle also applies the asymmetric signed range limit on the quotient. The data width `W` is a parameter.

Top module: `seq_wide_divider`

## Requirements
- R1: A zero divisor ends the operation with `err` = 1 (divide by zero), and `done` is high in the first cycle after the edge that samples `start`. `quotient` and `remainder` keep their previous values.
- R2: When the magnitude of the upper dividend half is greater than or equal to the divisor magnitude, the block reports `err` = 2 (overflow) without iterating. `done` is high in the first cycle after the sampling edge.
- R3: In unsigned mode (`signed_mode` = 0), a divide that cannot overflow returns quotient = floor(D/d) and remainder = D mod d, where D = {dividend_hi, dividend_lo}. It ends with `err` = 0, and `done` is high W+1 cycles after the first cycle following the sampling edge (W+2 edges in total).
- R4: A dividend with a zero upper half gives the plain single-width division of the lower half.
- R5: In signed mode, the quotient is rounded toward zero and the remainder takes the sign of the dividend.
- R6: In signed mode, when the operand signs differ, a quotient magnitude above 2^(W-1) is an overflow (`err` = 2), so -2^(W-1) is still returned. When the signs match, a magnitude of 2^(W-1) or more is an overflow. This late overflow is reported at the full-length latency and writes no result.
- R7: `done` is a single-cycle pulse. `err` carries 0 for success, 1 for divide by zero and 2 for overflow.
- R8: `quotient`, `remainder` and `err` change only when `done` is raised. They hold their values until the next completion.
- R9: A `start` pulse while `busy` is high is ignored. The running operation completes with its own operands, and no extra completion follows.
- R10: After a synchronous active-low reset, `busy`, `done`, `err`, `quotient` and `remainder` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| signed_mode | input | 1 | 1 selects two's-complement operands |
| dividend_hi | input | W | Upper half of the dividend |
| dividend_lo | input | W | Lower half of the dividend |
| divisor | input | W | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Completion status: 0 ok, 1 zero divisor, 2 overflow |
| quotient | output | W | Quotient of the last successful operation |
| remainder | output | W | Remainder of the last successful operation |

## Verification
The hardest case to reach is the signed overflow that appears only after the loop, because the early upper-half test does not catch it. The quotient magnitude must land exactly on 2^(W-1). With equal signs that magnitude is an overflow, and with opposite signs it is a legal -2^(W-1). The stimulus builds these dividends directly as 3·2^(W-1) and ±2^(W-1) against divisors of 3 and -1. It also covers the divisor whose negation is itself, and an unsigned case where the upper half sits one below the divisor, so that a bit is carried out of the shifted partial remainder on every step. A start pulse is injected mid-run to show that it is discarded.

// File: rtl/wdiv_pkg.sv
// Shared types for the sequential double-width divider.
package wdiv_pkg;
    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_ZERO = 2'd1,
        ERR_OVF  = 2'd2
    } div_err_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIX  = 2'd2
    } div_phase_e;
endpackage

// File: rtl/wdiv_prep.sv
// Operand conditioning: converts signed operands to magnitudes, flags a zero
// divisor and an upper half too large to give a W-bit quotient.
// Assumes W >= 2; purely combinational.
module wdiv_prep #(
    parameter int W = 16
) (
    input  logic         signed_mode,
    input  logic [W-1:0] num_hi,
    input  logic [W-1:0] num_lo,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] mag_hi,
    output logic [W-1:0] mag_lo,
    output logic [W-1:0] mag_dvs,
    output logic         neg_num,
    output logic         neg_dvs,
    output logic         zero_dvs,
    output logic         early_ovf
);
    localparam int DW = 2 * W;

    logic [DW-1:0] num_full;
    logic [DW-1:0] num_abs;

    // Form magnitudes and the pre-loop error conditions.
    always_comb begin
        neg_num   = signed_mode & num_hi[W-1];
        neg_dvs   = signed_mode & dvs[W-1];
        num_full  = {num_hi, num_lo};
        num_abs   = neg_num ? (~num_full + {{(DW-1){1'b0}}, 1'b1}) : num_full;
        mag_hi    = num_abs[DW-1:W];
        mag_lo    = num_abs[W-1:0];
        mag_dvs   = neg_dvs ? (~dvs + {{(W-1){1'b0}}, 1'b1}) : dvs;
        zero_dvs  = (dvs == '0);
        early_ovf = (mag_hi >= mag_dvs);
    end
endmodule

// File: rtl/wdiv_step.sv
// One restoring division step: shifts the {hi, lo} pair left by one bit,
// subtracts the divisor when the shifted partial remainder reaches it (or a
// bit left the top), and shifts the quotient bit into lo. Combinational.
module wdiv_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    logic [W-1:0] hi_sh;
    logic         take;

    // Shift, compare, conditionally subtract.
    always_comb begin
        hi_sh = {hi_i[W-2:0], lo_i[W-1]};
        take  = hi_i[W-1] | (hi_sh >= dvs_i);
        hi_o  = take ? (hi_sh - dvs_i) : hi_sh;
        lo_o  = {lo_i[W-2:0], take};
    end
endmodule

// File: rtl/wdiv_fix.sv
// Sign restoration and signed range check on the magnitude quotient.
// Assumes neg_num and neg_dvs are already zero in unsigned mode.
module wdiv_fix #(
    parameter int W = 16
) (
    input  logic         signed_mode,
    input  logic         neg_num,
    input  logic         neg_dvs,
    input  logic [W-1:0] q_mag,
    input  logic [W-1:0] r_mag,
    output logic [W-1:0] q_o,
    output logic [W-1:0] r_o,
    output logic         ovf
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    logic flip;

    // Apply asymmetric limit and restore signs.
    always_comb begin
        flip = neg_num ^ neg_dvs;
        ovf  = signed_mode & (flip ? (q_mag > HALF) : (q_mag >= HALF));
        q_o  = flip ? (~q_mag + {{(W-1){1'b0}}, 1'b1}) : q_mag;
        r_o  = neg_num ? (~r_mag + {{(W-1){1'b0}}, 1'b1}) : r_mag;
    end
endmodule

// File: rtl/seq_wide_divider.sv
// Sequential 2W-by-W divider. On an accepted start it checks for a zero
// divisor and an oversized upper half (one-cycle error completion), otherwise
// iterates W restoring steps, then spends one cycle on sign fix-up and the
// signed range check. Results and status register only at completion.
// Assumes W >= 2; start is ignored while busy.
module seq_wide_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] dividend_hi,
    input  logic [W-1:0] dividend_lo,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [1:0]   err,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    import wdiv_pkg::*;

    localparam int              CW   = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0]   LAST = CW'(W - 1);

    div_phase_e   phase;
    logic [CW-1:0] cnt;
    logic [W-1:0] acc_hi, acc_lo, dvs_q;
    logic         sgn_q, negn_q, negd_q;
    logic         done_q;
    div_err_e     err_q;
    logic [W-1:0] quo_q, rem_q;

    logic [W-1:0] p_hi, p_lo, p_dvs;
    logic         p_negn, p_negd, p_zero, p_ovf;
    logic [W-1:0] s_hi, s_lo;
    logic [W-1:0] f_q, f_r;
    logic         f_ovf;

    wdiv_prep #(.W(W)) u_prep (
        .signed_mode (signed_mode),
        .num_hi      (dividend_hi),
        .num_lo      (dividend_lo),
        .dvs         (divisor),
        .mag_hi      (p_hi),
        .mag_lo      (p_lo),
        .mag_dvs     (p_dvs),
        .neg_num     (p_negn),
        .neg_dvs     (p_negd),
        .zero_dvs    (p_zero),
        .early_ovf   (p_ovf)
    );

    wdiv_step #(.W(W)) u_step (
        .hi_i  (acc_hi),
        .lo_i  (acc_lo),
        .dvs_i (dvs_q),
        .hi_o  (s_hi),
        .lo_o  (s_lo)
    );

    wdiv_fix #(.W(W)) u_fix (
        .signed_mode (sgn_q),
        .neg_num     (negn_q),
        .neg_dvs     (negd_q),
        .q_mag       (acc_lo),
        .r_mag       (acc_hi),
        .q_o         (f_q),
        .r_o         (f_r),
        .ovf         (f_ovf)
    );

    // Control sequence, iteration registers and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            acc_hi <= '0;
            acc_lo <= '0;
            dvs_q  <= '0;
            sgn_q  <= 1'b0;
            negn_q <= 1'b0;
            negd_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= ERR_NONE;
            quo_q  <= '0;
            rem_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        if (p_zero) begin
                            done_q <= 1'b1;
                            err_q  <= ERR_ZERO;
                        end else if (p_ovf) begin
                            done_q <= 1'b1;
                            err_q  <= ERR_OVF;
                        end else begin
                            acc_hi <= p_hi;
                            acc_lo <= p_lo;
                            dvs_q  <= p_dvs;
                            sgn_q  <= signed_mode;
                            negn_q <= p_negn;
                            negd_q <= p_negd;
                            cnt    <= '0;
                            phase  <= PH_RUN;
                        end
                    end
                end
                PH_RUN: begin
                    acc_hi <= s_hi;
                    acc_lo <= s_lo;
                    cnt    <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        phase <= PH_FIX;
                    end
                end
                PH_FIX: begin
                    done_q <= 1'b1;
                    phase  <= PH_IDLE;
                    if (f_ovf) begin
                        err_q <= ERR_OVF;
                    end else begin
                        err_q <= ERR_NONE;
                        quo_q <= f_q;
                        rem_q <= f_r;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy      = (phase != PH_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign quotient  = quo_q;
    assign remainder = rem_q;
endmodule

// File: rtl/wdiv_checker.sv
// Port-level temporal checks for seq_wide_divider, attached by bind.
module wdiv_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [1:0]   err,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder
);
    AST_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor == '0) |=> (done && err == 2'd1)); // R1

    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy || done)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(err))); // R8

    AST_NO_WRITE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err != 2'd0) |-> ($stable(quotient) && $stable(remainder))); // R1

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
endmodule

bind seq_wide_divider wdiv_checker #(.W(W)) u_wdiv_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/tb_seq_wide_divider.sv
module tb_seq_wide_divider;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] dividend_hi = '0;
    logic [W-1:0] dividend_lo = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done;
    logic [1:0]   err;
    logic [W-1:0] quotient, remainder;

    seq_wide_divider #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .dividend_hi(dividend_hi), .dividend_lo(dividend_lo), .divisor(divisor),
        .busy(busy), .done(done), .err(err), .quotient(quotient), .remainder(remainder)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [1:0]   err;
        logic [W-1:0] q;
        logic [W-1:0] r;
        int           lat;
        int           t0;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    int           total = 0;
    int           bad = 0;
    int           cyc = 0;
    int           stray = 0;
    logic [W-1:0] last_q = '0;
    logic [W-1:0] last_r = '0;
    bit           finished = 0;
    logic [31:0]  rs = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    // Reference model built from the requirements.
    function automatic exp_t model(bit sg, logic [W-1:0] hi, logic [W-1:0] lo,
                                   logic [W-1:0] dv, string tag);
        exp_t   e;
        longint nD, nd, mD, md, qm, rm, qv, rv;
        bit     nn, ndn;
        e.tag = tag; e.lat = 1; e.q = '0; e.r = '0; e.t0 = 0;
        nD = sg ? longint'($signed({hi, lo})) : longint'({hi, lo});
        nd = sg ? longint'($signed(dv)) : longint'(dv);
        nn = (nD < 0); ndn = (nd < 0);
        mD = nn ? -nD : nD;
        md = ndn ? -nd : nd;
        if (dv == '0) begin
            e.err = 2'd1;
        end else if ((mD >> W) >= md) begin
            e.err = 2'd2;
        end else begin
            qm = mD / md; rm = mD % md;
            e.lat = W + 2;
            if (sg && (nn != ndn) && qm > (64'sd1 << (W-1))) e.err = 2'd2;
            else if (sg && (nn == ndn) && qm >= (64'sd1 << (W-1))) e.err = 2'd2;
            else begin
                e.err = 2'd0;
                qv = (nn != ndn) ? -qm : qm;
                rv = nn ? -rm : rm;
                e.q = qv[W-1:0];
                e.r = rv[W-1:0];
            end
        end
        return e;
    endfunction

    // Driver: waits for idle, pushes the expected item, pulses start.
    task automatic go(input bit sg, input logic [W-1:0] hi, input logic [W-1:0] lo,
                      input logic [W-1:0] dv, input string tag);
        exp_t e;
        while (busy) @(negedge clk);
        e = model(sg, hi, lo, dv, tag);
        e.t0 = cyc;
        signed_mode = sg; dividend_hi = hi; dividend_lo = lo; divisor = dv;
        start = 1'b1;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    // Monitor: pops and compares on each completion.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                stray++;
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(err == e.err, e.tag, "err", err, e.err);
                chk((cyc - e.t0) == e.lat, e.tag, "latency", cyc - e.t0, e.lat);
                if (e.err == 2'd0) begin
                    chk(quotient == e.q, e.tag, "quotient", quotient, e.q);
                    chk(remainder == e.r, e.tag, "remainder", remainder, e.r);
                    last_q = e.q; last_r = e.r;
                end else begin
                    chk(quotient == last_q, "R8", "quotient kept on error", quotient, last_q);
                    chk(remainder == last_r, "R8", "remainder kept on error", remainder, last_r);
                end
            end
        end
    end

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R10", "busy/done in reset", {busy, done}, 0);
        chk(err == 2'd0, "R10", "err in reset", err, 0);
        chk(quotient == '0 && remainder == '0, "R10", "results in reset", {quotient, remainder}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        go(0, 16'h0000, 16'd1000, 16'd7, "R4");
        go(0, 16'h0000, 16'hFFFF, 16'h0001, "R4");
        go(0, 16'h0012, 16'h3456, 16'h1234, "R3");
        go(0, 16'hFFFE, 16'hFFFF, 16'hFFFF, "R3");
        go(0, 16'h0001, 16'h0000, 16'h0002, "R3");
        go(0, 16'h0005, 16'h0000, 16'h0005, "R2");
        go(0, 16'hFFFF, 16'h1234, 16'h0010, "R2");
        go(0, 16'h0003, 16'h0003, 16'h0000, "R1");
        go(1, 16'hFFFF, 16'hFFF9, 16'h0002, "R5");
        go(1, 16'h0000, 16'h0007, 16'hFFFE, "R5");
        go(1, 16'hFFFF, 16'hFFF9, 16'hFFFE, "R5");
        go(1, 16'hFFFF, 16'hFFFF, 16'h0000, "R1");
        go(1, 16'h0001, 16'h8000, 16'h0003, "R6");
        go(1, 16'hFFFE, 16'h8000, 16'h0003, "R6");
        go(1, 16'h0000, 16'h8000, 16'hFFFF, "R6");
        go(1, 16'hFFFF, 16'h8000, 16'hFFFF, "R6");
        go(1, 16'h8000, 16'h0000, 16'h8000, "R2");
        go(1, 16'hC000, 16'h0000, 16'h8000, "R5");

        for (int i = 0; i < 30; i++) begin
            logic [W-1:0] dv, hi, lo;
            dv = rnd() | 16'h0001;
            hi = rnd() % dv;
            lo = rnd();
            go(0, hi, lo, dv, "R3");
        end
        for (int i = 0; i < 30; i++) begin
            logic [W-1:0] dv, hi, lo;
            logic [31:0] a;
            dv = rnd(); a = rnd();
            hi = {{9{a[31]}}, a[6:0]};
            lo = rnd();
            go(1, hi, lo, dv, "R5");
        end

        // R8: results hold after completion.
        go(0, 16'h0000, 16'd500, 16'd9, "R3");
        repeat (6) @(negedge clk);
        chk(quotient == 16'd55 && remainder == 16'd5, "R8", "hold after done",
            {quotient, remainder}, {16'd55, 16'd5});

        // R9: start while busy is discarded.
        begin
            exp_t e;
            e = model(0, 16'h0000, 16'd100, 16'd3, "R9");
            e.t0 = cyc;
            signed_mode = 0; dividend_hi = 0; dividend_lo = 16'd100; divisor = 16'd3;
            start = 1'b1;
            sb.push_back(e);
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            chk(busy == 1'b1, "R9", "busy mid-run", busy, 1);
            dividend_lo = 16'd7; divisor = 16'd0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (sb.size() != 0) @(negedge clk);
            repeat (W + 6) @(negedge clk);
            chk(stray == 0, "R9", "extra completions", stray, 0);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule